// File: doc/BRIEF.md
# Resonant Gate Edge Timer

This block generates one gate-drive pulse per switching cycle for a resonant power stage. A free-running tick counter advances once per clock, and each clock is one 5 ns timing step. At every cycle boundary the block latches a new cycle length. That length is the larger of two values: a 12-bit period request from an upstream regulation loop, and a programmed minimum cycle. Keeping the cycle at or above the minimum caps the switching frequency.

Inside a cycle the gate rises after a programmed delay counted from the cycle start. The gate falls at the cycle midpoint moved by a signed offset: later for positive codes, earlier for negative ones. Settings are written one byte at a time through a small write port. They are held in a pending bank and copied into the active timing only at a cycle boundary, so no cycle runs on a mix of old and new values. A one-clock strobe marks the first tick of every cycle.

Top module: `reso_edge_gen`

## Requirements
- R1: While `rst_ni` is low, `gate_o` and `cyc_start_o` are 0. The first rising clock edge after release starts a cycle, so `cyc_start_o` is 1 in the first clock after release.
- R2: Write select 0 sets the rise delay and select 1 sets the fall offset code. Select 2 sets bits [11:4] of the minimum cycle. Select 3 sets bits [3:0] of the minimum cycle from `wr_data_i[7:4]`, and `wr_data_i[3:0]` is ignored on that select. All registers reset to 0.
- R3: At each cycle start the cycle length P is latched as max(`period_req_i`, minimum cycle). The next `cyc_start_o` follows exactly P ticks later. A P of 0 or 1 gives one-tick cycles.
- R4: `cyc_start_o` is 1 for the first tick of each cycle (tick 0) and 0 on every other tick.
- R5: The gate is high from tick r, where r is the unsigned 8-bit rise delay (0 to 255 ticks).
- R6: A fall code c from 0x00 to 0x7F places the falling edge at tick M + c, where M is the midpoint. The gate is low again from that tick.
- R7: A fall code c from 0x80 to 0xFF places the falling edge at tick M − (256 − c). So 0x80 leads the midpoint by 128 ticks and 0xFF leads it by 1 tick.
- R8: The midpoint M is floor(P / 2) of the latched cycle length.
- R9: If the fall tick F satisfies F ≤ r or F > P, the gate stays low for the whole cycle.
- R10: Register writes change only the pending settings. A cycle already in progress keeps its rise delay, fall offset and length. The new values apply from the next cycle start.
- R11: An upper minimum byte of 0x10 with a lower nibble of 0x9 gives a minimum of 265 ticks, which holds cycles at 265 ticks when the request is shorter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Tick clock, one 5 ns step per cycle |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select for a write |
| wr_data_i | input | 8 | Register write data |
| period_req_i | input | 12 | Requested cycle length in ticks |
| gate_o | output | 1 | Gate-drive output |
| cyc_start_o | output | 1 | High on the first tick of each cycle |

## Verification
The bench uses the default 12-bit period and 8-bit timing fields. It sweeps every rise delay and every fall offset that lands near or inside short cycles of 0 to 9 ticks. This exercises one-tick cycles, fall edges at or before the rise, and fall edges beyond the cycle end on every edge of the window. The clamp source alternates between the request and the minimum across the sweep. Separate longer cycles cover the extreme offset codes 0x80, 0xFF and 0x7F, the largest rise delay, the 265-tick minimum, and a write made in the middle of a cycle.

// File: rtl/reso_pkg.sv
package reso_pkg;
  localparam int PER_W  = 12;
  localparam int BYTE_W = 8;
  localparam int LO_W   = PER_W - BYTE_W;
  localparam int SEL_W  = 2;

  localparam logic [SEL_W-1:0] SEL_RISE   = 2'd0;
  localparam logic [SEL_W-1:0] SEL_FOFF   = 2'd1;
  localparam logic [SEL_W-1:0] SEL_MIN_HI = 2'd2;
  localparam logic [SEL_W-1:0] SEL_MIN_LO = 2'd3;

  typedef struct packed {
    logic [BYTE_W-1:0] rise;
    logic [BYTE_W-1:0] foff;
    logic [PER_W-1:0]  min_cyc;
  } cfg_t;
endpackage

// File: rtl/reso_cfg_bank.sv
module reso_cfg_bank
  import reso_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  output cfg_t              cfg_o
);
  cfg_t cfg_q;

  // pending bank; copied into active timing at cycle boundaries elsewhere
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (wr_en_i) begin
      case (wr_sel_i)
        SEL_RISE:   cfg_q.rise <= wr_data_i;
        SEL_FOFF:   cfg_q.foff <= wr_data_i;
        SEL_MIN_HI: cfg_q.min_cyc[PER_W-1 -: BYTE_W] <= wr_data_i;
        default:    cfg_q.min_cyc[LO_W-1:0] <= wr_data_i[BYTE_W-1 -: LO_W];
      endcase
    end
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/reso_period_seq.sv
module reso_period_seq
  import reso_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PER_W-1:0] period_req_i,
  input  logic [PER_W-1:0] min_cyc_i,
  output logic [PER_W-1:0] cnt_o,
  output logic [PER_W-1:0] per_o,
  output logic [PER_W-1:0] eff_o,
  output logic             load_o,
  output logic             cyc_start_o
);
  logic [PER_W-1:0] cnt_q, per_q;
  logic [PER_W:0]   cnt_inc;
  logic             start_q;

  assign eff_o   = (period_req_i >= min_cyc_i) ? period_req_i : min_cyc_i;
  assign cnt_inc = {1'b0, cnt_q} + (PER_W+1)'(1);
  // per_q of 0 or 1 makes every tick a boundary
  assign load_o  = (cnt_inc >= {1'b0, per_q});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      per_q   <= '0;
      start_q <= 1'b0;
    end else begin
      start_q <= load_o;
      if (load_o) begin
        cnt_q <= '0;
        per_q <= eff_o;
      end else begin
        cnt_q <= cnt_inc[PER_W-1:0];
      end
    end
  end

  assign cnt_o       = cnt_q;
  assign per_o       = per_q;
  assign cyc_start_o = start_q;
endmodule

// File: rtl/reso_edge_plan.sv
module reso_edge_plan
  import reso_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [PER_W-1:0]  eff_i,
  input  logic [BYTE_W-1:0] rise_i,
  input  logic [BYTE_W-1:0] foff_i,
  input  logic [PER_W-1:0]  cnt_i,
  output logic [BYTE_W-1:0] rise_o,
  output logic              gate_o
);
  localparam int SW = PER_W + 2;

  logic signed [SW-1:0] mid_s, off_s, rnew_s, per_s, fnew_s, nxt_s, ract_s;
  logic signed [SW-1:0] fall_q;
  logic [BYTE_W-1:0]    rise_q;
  logic                 ok_q, ok_new, gate_q, gate_d;

  assign mid_s  = $signed({2'b00, eff_i >> 1});
  assign off_s  = $signed({{(SW-BYTE_W){foff_i[BYTE_W-1]}}, foff_i});
  assign rnew_s = $signed({{(SW-BYTE_W){1'b0}}, rise_i});
  assign per_s  = $signed({2'b00, eff_i});
  assign fnew_s = mid_s + off_s;
  // window must open before it closes and close within the cycle
  assign ok_new = (fnew_s > rnew_s) && (fnew_s <= per_s);

  assign ract_s = $signed({{(SW-BYTE_W){1'b0}}, rise_q});
  assign nxt_s  = $signed({2'b00, cnt_i} + SW'(1));

  // gate is registered against the counter's next value: glitch-free, tick-aligned
  always_comb begin
    if (load_i) gate_d = ok_new && (rise_i == '0);
    else        gate_d = ok_q && (nxt_s >= ract_s) && (nxt_s < fall_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rise_q <= '0;
      fall_q <= '0;
      ok_q   <= 1'b0;
      gate_q <= 1'b0;
    end else begin
      gate_q <= gate_d;
      if (load_i) begin
        rise_q <= rise_i;
        fall_q <= fnew_s;
        ok_q   <= ok_new;
      end
    end
  end

  assign rise_o = rise_q;
  assign gate_o = gate_q;
endmodule

// File: rtl/reso_edge_gen.sv
module reso_edge_gen
  import reso_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic [PER_W-1:0]  period_req_i,
  output logic              gate_o,
  output logic              cyc_start_o
);
  cfg_t              cfg;
  logic [PER_W-1:0]  cnt_q, per_q, eff;
  logic [BYTE_W-1:0] rise_q;
  logic              load;

  reso_cfg_bank u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .cfg_o     (cfg)
  );

  reso_period_seq u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .period_req_i (period_req_i),
    .min_cyc_i    (cfg.min_cyc),
    .cnt_o        (cnt_q),
    .per_o        (per_q),
    .eff_o        (eff),
    .load_o       (load),
    .cyc_start_o  (cyc_start_o)
  );

  reso_edge_plan u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .eff_i  (eff),
    .rise_i (cfg.rise),
    .foff_i (cfg.foff),
    .cnt_i  (cnt_q),
    .rise_o (rise_q),
    .gate_o (gate_o)
  );
endmodule

// File: rtl/reso_edge_gen_chk.sv
module reso_edge_gen_chk
  import reso_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              gate_o,
  input logic              cyc_start_o,
  input logic [PER_W-1:0]  period_req_i,
  input logic [PER_W-1:0]  min_cyc,
  input logic [PER_W-1:0]  cnt_q,
  input logic [PER_W-1:0]  per_q,
  input logic [BYTE_W-1:0] rise_q
);
  p_start_at_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_start_o |-> cnt_q == '0);

  p_count_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) |-> cnt_q == PER_W'($past(cnt_q) + PER_W'(1)));

  p_clamp_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_start_o |-> (per_q >= $past(period_req_i)) && (per_q >= $past(min_cyc)));

  p_single_strobe_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_start_o && per_q > PER_W'(1)) |=> !cyc_start_o);

  p_rise_at_delay_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_o) |-> cnt_q == PER_W'(rise_q));

  p_zero_len_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (per_q == '0) |-> !gate_o);
endmodule

bind reso_edge_gen reso_edge_gen_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .gate_o       (gate_o),
  .cyc_start_o  (cyc_start_o),
  .period_req_i (period_req_i),
  .min_cyc      (cfg.min_cyc),
  .cnt_q        (cnt_q),
  .per_q        (per_q),
  .rise_q       (rise_q)
);

// File: tb/tb_reso_edge_gen.sv
module tb_reso_edge_gen;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_sel_i = '0;
  logic [7:0]  wr_data_i = '0;
  logic [11:0] period_req_i = '0;
  logic        gate_o, cyc_start_o;

  int checks = 0;
  int fails  = 0;

  always #4 clk_i = ~clk_i;

  reso_edge_gen dut (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en_i),
    .wr_sel_i     (wr_sel_i),
    .wr_data_i    (wr_data_i),
    .period_req_i (period_req_i),
    .gate_o       (gate_o),
    .cyc_start_o  (cyc_start_o)
  );

  initial begin
    repeat (190000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    wr_en_i = 1'b1; wr_sel_i = s; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  // R2: select 3 carries data[7:4]; low nibble driven with junk 0xA
  task automatic configure(input int req, input int r, input int code, input int minv);
    logic [11:0] m;
    m = 12'(minv);
    period_req_i = 12'(req);
    wr(2'd0, 8'(r));
    wr(2'd1, 8'(code));
    wr(2'd2, m[11:4]);
    wr(2'd3, {m[3:0], 4'hA});
  endtask

  task automatic check_cycle(input int p, input int r, input int code, input string tag,
                             input bit aligned);
    int len, f, soff;
    bit ok, bad, eg, es;
    len  = (p < 1) ? 1 : p;
    soff = (code >= 128) ? code - 256 : code;
    f    = (p >> 1) + soff;
    ok   = (f > r) && (f <= p);
    bad  = 1'b0;
    if (!aligned) begin
      @(negedge clk_i);
      while (!cyc_start_o) @(negedge clk_i);
    end
    for (int t = 0; t < len; t++) begin
      eg = ok && (t >= r) && (t < f);
      es = (t == 0);
      if (!bad && (gate_o !== eg || cyc_start_o !== es)) begin
        bad = 1'b1;
        $display("FAIL %s P=%0d r=%0d code=%02h tick %0d: gate=%b start=%b expected gate=%b start=%b",
                 tag, p, r, code, t, gate_o, cyc_start_o, eg, es);
      end
      @(negedge clk_i);
    end
    if (!bad && cyc_start_o !== 1'b1) begin
      bad = 1'b1;
      $display("FAIL R3 P=%0d: start after %0d ticks=%b expected 1", p, len, cyc_start_o);
    end
    checks++;
    if (bad) fails++;
  endtask

  initial begin
    int soff, f;
    bit bad;
    // R1: reset state
    bad = 1'b0;
    repeat (3) begin
      @(negedge clk_i);
      if (gate_o !== 1'b0 || cyc_start_o !== 1'b0) bad = 1'b1;
    end
    checks++;
    if (bad) begin
      fails++;
      $display("FAIL R1 in reset: gate=%b start=%b expected 0 0", gate_o, cyc_start_o);
    end
    rst_ni = 1'b1;
    @(negedge clk_i);
    checks++;
    if (cyc_start_o !== 1'b1 || gate_o !== 1'b0) begin
      fails++;
      $display("FAIL R1 first clock: gate=%b start=%b expected 0 1", gate_o, cyc_start_o);
    end

    // Sweep: R2 R3 R4 R5 R8 on every cycle; R6/R7/R9 by tag
    for (int p = 0; p <= 9; p++) begin
      for (int r = 0; r <= p + 1; r++) begin
        for (int off = -(p/2 + 2); off <= p/2 + 2; off++) begin
          int code;
          string tag;
          code = off & 255;
          f = (p >> 1) + off;
          tag = !((f > r) && (f <= p)) ? "R9" : (off >= 0 ? "R6" : "R7");
          if (((r + off) & 1) != 0) configure(p, r, code, 0);
          else                      configure(p / 2, r, code, p);
          check_cycle(p, r, code, tag, 1'b0);
        end
      end
    end

    // R7 extremes and R6 maximum trailing code, R5 largest delay
    configure(600, 0, 8'h80, 0);   check_cycle(600, 0, 8'h80, "R7", 1'b0);
    configure(600, 10, 8'hFF, 0);  check_cycle(600, 10, 8'hFF, "R7", 1'b0);
    configure(600, 20, 8'h7F, 0);  check_cycle(600, 20, 8'h7F, "R6", 1'b0);
    configure(600, 255, 8'h00, 0); check_cycle(600, 255, 8'h00, "R5", 1'b0);
    configure(520, 255, 8'h05, 0); check_cycle(520, 255, 8'h05, "R9", 1'b0);

    // R11: minimum 0x10/0x9 = 265 ticks over a shorter request
    configure(100, 3, 0, 265); check_cycle(265, 3, 0, "R11", 1'b0);
    configure(300, 3, 0, 265); check_cycle(300, 3, 0, "R3", 1'b0);

    // R10: write mid-cycle; running cycle keeps old rise, next takes new
    configure(40, 10, 0, 0);
    check_cycle(40, 10, 0, "R10", 1'b0);
    bad = 1'b0;
    for (int t = 0; t < 40; t++) begin
      bit eg;
      eg = (t >= 10) && (t < 20);
      if (gate_o !== eg) begin
        if (!bad) $display("FAIL R10 tick %0d: gate=%b expected %b", t, gate_o, eg);
        bad = 1'b1;
      end
      if (t == 3) begin wr_en_i = 1'b1; wr_sel_i = 2'd0; wr_data_i = 8'd15; end
      if (t == 4) wr_en_i = 1'b0;
      @(negedge clk_i);
    end
    checks++;
    if (bad) fails++;
    check_cycle(40, 15, 0, "R10", 1'b1);

    soff = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails + soff);
    $finish;
  end
endmodule